// File: doc/BRIEF.md
# Burst Address Generator for a DMA Channel

This block is the address and count engine of one DMA channel. Software first programs two start addresses, a burst-size field, per-side signed burst and transfer steps, a transfer-size field and a word-size select. After a start command, every peripheral trigger launches one burst. A burst moves one word per clock. On each word the block asserts a read strobe and a write strobe together, each with its own address. When the programmed number of bursts is done, the channel stops and raises a one-cycle end-of-transfer interrupt. The memory, arbitration between channels and address wrapping all live outside this block.

The two word sizes differ in two ways. The first is how the burst field is counted: in 16-bit mode it is the word count minus one, and in 32-bit mode it is the number of 16-bit address units. The second is where the pointer sits once a burst ends: in 16-bit mode it stays on the last word moved, and in 32-bit mode it has already stepped past that word. The transfer step must make up for this difference. A typical use re-reads a small result block on every burst and writes the data to a destination that keeps advancing.

Top module: `dma_addr_engine`

## Requirements
- R1: After reset, busy, rd_en, wr_en and done_irq are 0, and rd_addr and wr_addr are 0.
- R2: With cfg_wide=0, a burst field of N moves N+1 words, one per cycle, with rd_en and wr_en high together. After every word except the last one, each address adds its sign-extended burst step.
- R3: With cfg_wide=1, a burst field of N moves N/2 words (at least one word). The burst step is also added after the last word of the burst.
- R4: At the end of a burst, the pointer gets the transfer step added as well. With cfg_wide=0 this starts from the address of the last word; with cfg_wide=1 it starts one burst step past that address. So re-reading 8 words takes a step of -7 at width 16 and -8 at width 32, and continuing at width 32 takes a step of 0.
- R5: A transfer-size field of M runs M+1 bursts. In the cycle after the last strobe, done_irq is high for exactly one cycle and busy is already 0. The pointers keep their final values.
- R6: A trigger that arrives while the channel waits yields its first strobe two clock edges later. A trigger that arrives during a burst is held and starts the next burst after one wait cycle.
- R7: A trigger while the channel is stopped, including in the cycle of a start command, is ignored and leaves no pending trigger.
- R8: A start pulse from a fresh stop loads both start addresses and the burst count. busy is high from the next cycle on.
- R9: A halt pulse stops a waiting channel at the next edge. During a burst, the channel finishes that burst and then stops. A later start pulse resumes from the held pointers and the remaining burst count.
- R10: A soft-reset pulse aborts at the next edge. It clears busy, the strobes, any pending trigger and both pointers, and the next start is fresh.
- R11: A force pulse acts as a trigger. A clear-trigger pulse discards a held trigger and wins over a trigger in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_run | input | 1 | Start or resume pulse |
| ctl_halt | input | 1 | Halt pulse |
| ctl_srst | input | 1 | Soft-reset pulse |
| ctl_force | input | 1 | Software trigger pulse |
| ctl_clr | input | 1 | Discard pending trigger pulse |
| per_trig | input | 1 | Peripheral trigger pulse |
| cfg_wide | input | 1 | 1 = 32-bit words, 0 = 16-bit words |
| cfg_burst | input | BW | Burst-size field |
| cfg_xfer | input | TW | Transfer-size field (bursts minus one) |
| cfg_src_base | input | AW | Source start address |
| cfg_dst_base | input | AW | Destination start address |
| cfg_src_bstep | input | SW | Signed source burst step |
| cfg_dst_bstep | input | SW | Signed destination burst step |
| cfg_src_tstep | input | SW | Signed source transfer step |
| cfg_dst_tstep | input | SW | Signed destination transfer step |
| rd_addr | output | AW | Source address |
| rd_en | output | 1 | Read strobe |
| wr_addr | output | AW | Destination address |
| wr_en | output | 1 | Write strobe |
| busy | output | 1 | Channel running |
| done_irq | output | 1 | End-of-transfer pulse |

## Verification
The assertions check, on every cycle, the following local rules:
- a pointer adds its burst step inside a burst and holds still between bursts;
- the narrow end-of-burst update adds the transfer step alone;
- the interrupt lasts one cycle and arrives with busy low;
- a stopped channel holds no trigger;
- a burst only begins from a held trigger;
- soft reset and start take effect at the next edge.

Only the bench scenarios can show the full address sequences:
- the burst counts produced by each field encoding;
- re-reading a block against continuing through it;
- trigger latency and trigger queuing;
- halt-and-resume continuity across bursts.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BURST = 2'd2
    } agen_state_e;

    localparam int unsigned DEF_AW = 16;
    localparam int unsigned DEF_SW = 8;
    localparam int unsigned DEF_BW = 6;
    localparam int unsigned DEF_TW = 10;

endpackage

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit #(
    parameter int unsigned AW = 16,
    parameter int unsigned SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic          adv,
    input  logic          last,
    input  logic          wide,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] bstep,
    input  logic [SW-1:0] tstep,
    output logic [AW-1:0] ptr
);
    localparam int unsigned EXT = AW - SW;

    logic [AW-1:0] ptr_d, ptr_q;
    logic [AW-1:0] bext, text;

    always_comb begin
        bext  = {{EXT{bstep[SW-1]}}, bstep};
        text  = {{EXT{tstep[SW-1]}}, tstep};
        ptr_d = ptr_q;
        if (clear) begin
            ptr_d = '0;
        end else if (load) begin
            ptr_d = base;
        end else if (adv) begin
            if (last) begin
                // wide mode applies the final burst step before the transfer step
                ptr_d = wide ? (ptr_q + bext + text) : (ptr_q + text);
            end else begin
                ptr_d = ptr_q + bext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    AST_STEP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !last && !load && !clear) |=> ptr_q == $past(ptr_q) + $past(bext)); // R2
    AST_NARROW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last && !wide && !load && !clear) |=> ptr_q == $past(ptr_q) + $past(text)); // R4
    AST_PTR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load && !clear) |=> ptr_q == $past(ptr_q)); // R9

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_agen_pkg::*;
#(
    parameter int unsigned BW = 6,
    parameter int unsigned TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          halt,
    input  logic          srst,
    input  logic          force_trig,
    input  logic          clr_trig,
    input  logic          per_trig,
    input  logic          wide,
    input  logic [BW-1:0] burst_fld,
    input  logic [TW-1:0] xfer_fld,
    output logic          load_o,
    output logic          adv_o,
    output logic          last_o,
    output logic          clear_o,
    output logic          busy_o,
    output logic          irq_o
);
    typedef struct packed {
        agen_state_e   st;
        logic          pend;
        logic          halt_req;
        logic          parked;
        logic          irq;
        logic [TW-1:0] left;
        logic [BW-1:0] wcnt;
    } seq_regs_t;

    seq_regs_t     seq_d, seq_q;
    logic          fire;
    logic [BW-1:0] half_fld;
    logic [BW-1:0] words_m1;

    always_comb begin
        fire     = per_trig | force_trig;
        half_fld = burst_fld >> 1;
        if (wide) words_m1 = (half_fld == '0) ? '0 : (half_fld - 1'b1);
        else      words_m1 = burst_fld;

        seq_d     = seq_q;
        seq_d.irq = 1'b0;
        load_o    = 1'b0;

        if (srst) begin
            seq_d.st       = ST_IDLE;
            seq_d.pend     = 1'b0;
            seq_d.halt_req = 1'b0;
            seq_d.parked   = 1'b0;
            seq_d.left     = '0;
            seq_d.wcnt     = '0;
        end else begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (run) begin
                        seq_d.st       = ST_ARMED;
                        seq_d.parked   = 1'b0;
                        seq_d.halt_req = 1'b0;
                        if (!seq_q.parked) begin
                            seq_d.left = xfer_fld;
                            load_o     = 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    if (halt) begin
                        seq_d.st     = ST_IDLE;
                        seq_d.parked = 1'b1;
                    end else if (seq_q.pend) begin
                        seq_d.st   = ST_BURST;
                        seq_d.wcnt = words_m1;
                        seq_d.pend = 1'b0;
                    end
                end
                ST_BURST: begin
                    if (halt) seq_d.halt_req = 1'b1;
                    if (seq_q.wcnt != '0) begin
                        seq_d.wcnt = seq_q.wcnt - 1'b1;
                    end else if (seq_q.left == '0) begin
                        seq_d.st       = ST_IDLE;
                        seq_d.irq      = 1'b1;
                        seq_d.parked   = 1'b0;
                        seq_d.halt_req = 1'b0;
                    end else begin
                        seq_d.left = seq_q.left - 1'b1;
                        if (seq_q.halt_req || halt) begin
                            seq_d.st       = ST_IDLE;
                            seq_d.parked   = 1'b1;
                            seq_d.halt_req = 1'b0;
                        end else begin
                            seq_d.st = ST_ARMED;
                        end
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase

            // trigger bookkeeping: only a running channel keeps a trigger
            if (seq_d.st == ST_IDLE)               seq_d.pend = 1'b0;
            else if (clr_trig)                     seq_d.pend = 1'b0;
            else if (fire && seq_q.st != ST_IDLE)  seq_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st       <= ST_IDLE;
            seq_q.pend     <= 1'b0;
            seq_q.halt_req <= 1'b0;
            seq_q.parked   <= 1'b0;
            seq_q.irq      <= 1'b0;
            seq_q.left     <= '0;
            seq_q.wcnt     <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign adv_o   = (seq_q.st == ST_BURST);
    assign last_o  = (seq_q.wcnt == '0);
    assign clear_o = srst;
    assign busy_o  = (seq_q.st != ST_IDLE);
    assign irq_o   = seq_q.irq;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R5
    AST_IRQ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !busy_o); // R5
    AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE) |-> !seq_q.pend); // R7
    AST_BURST_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_BURST && $past(seq_q.st) == ST_ARMED) |-> $past(seq_q.pend)); // R6
    AST_SRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy_o && !adv_o)); // R10

endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
    import dma_agen_pkg::*;
#(
    parameter int unsigned AW = DEF_AW,
    parameter int unsigned SW = DEF_SW,
    parameter int unsigned BW = DEF_BW,
    parameter int unsigned TW = DEF_TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_run,
    input  logic          ctl_halt,
    input  logic          ctl_srst,
    input  logic          ctl_force,
    input  logic          ctl_clr,
    input  logic          per_trig,
    input  logic          cfg_wide,
    input  logic [BW-1:0] cfg_burst,
    input  logic [TW-1:0] cfg_xfer,
    input  logic [AW-1:0] cfg_src_base,
    input  logic [AW-1:0] cfg_dst_base,
    input  logic [SW-1:0] cfg_src_bstep,
    input  logic [SW-1:0] cfg_dst_bstep,
    input  logic [SW-1:0] cfg_src_tstep,
    input  logic [SW-1:0] cfg_dst_tstep,
    output logic [AW-1:0] rd_addr,
    output logic          rd_en,
    output logic [AW-1:0] wr_addr,
    output logic          wr_en,
    output logic          busy,
    output logic          done_irq
);
    localparam int unsigned NSIDE = 2;

    logic load, adv, last, clear;
    logic [AW-1:0] side_base  [NSIDE];
    logic [SW-1:0] side_bstep [NSIDE];
    logic [SW-1:0] side_tstep [NSIDE];
    logic [AW-1:0] side_ptr   [NSIDE];

    assign side_base[0]  = cfg_src_base;
    assign side_base[1]  = cfg_dst_base;
    assign side_bstep[0] = cfg_src_bstep;
    assign side_bstep[1] = cfg_dst_bstep;
    assign side_tstep[0] = cfg_src_tstep;
    assign side_tstep[1] = cfg_dst_tstep;

    dma_burst_seq #(.BW(BW), .TW(TW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctl_run),
        .halt       (ctl_halt),
        .srst       (ctl_srst),
        .force_trig (ctl_force),
        .clr_trig   (ctl_clr),
        .per_trig   (per_trig),
        .wide       (cfg_wide),
        .burst_fld  (cfg_burst),
        .xfer_fld   (cfg_xfer),
        .load_o     (load),
        .adv_o      (adv),
        .last_o     (last),
        .clear_o    (clear),
        .busy_o     (busy),
        .irq_o      (done_irq)
    );

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_ptr_unit #(.AW(AW), .SW(SW)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear),
            .load  (load),
            .adv   (adv),
            .last  (last),
            .wide  (cfg_wide),
            .base  (side_base[g]),
            .bstep (side_bstep[g]),
            .tstep (side_tstep[g]),
            .ptr   (side_ptr[g])
        );
    end

    assign rd_addr = side_ptr[0];
    assign wr_addr = side_ptr[1];
    assign rd_en   = adv;
    assign wr_en   = adv;

    AST_RUN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_run && !ctl_srst) |=> busy); // R8
    AST_SRST_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_srst |=> (rd_addr == '0 && wr_addr == '0)); // R10

endmodule

// File: tb/dma_addr_engine_test.sv
module dma_addr_engine_test;
    localparam int AW = 16, SW = 8, BW = 6, TW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_run = 0, ctl_halt = 0, ctl_srst = 0, ctl_force = 0, ctl_clr = 0, per_trig = 0;
    logic cfg_wide = 0;
    logic [BW-1:0] cfg_burst = '0;
    logic [TW-1:0] cfg_xfer = '0;
    logic [AW-1:0] cfg_src_base = '0, cfg_dst_base = '0;
    logic [SW-1:0] cfg_src_bstep = '0, cfg_dst_bstep = '0, cfg_src_tstep = '0, cfg_dst_tstep = '0;
    logic [AW-1:0] rd_addr, wr_addr;
    logic rd_en, wr_en, busy, done_irq;

    int n_chk = 0, n_bad = 0;
    int ln = 0, irqn = 0;
    logic [AW-1:0] lsrc [0:63];
    logic [AW-1:0] ldst [0:63];

    always #10 clk = ~clk;

    dma_addr_engine #(.AW(AW), .SW(SW), .BW(BW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run), .ctl_halt(ctl_halt),
        .ctl_srst(ctl_srst), .ctl_force(ctl_force), .ctl_clr(ctl_clr),
        .per_trig(per_trig), .cfg_wide(cfg_wide), .cfg_burst(cfg_burst),
        .cfg_xfer(cfg_xfer), .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
        .cfg_src_bstep(cfg_src_bstep), .cfg_dst_bstep(cfg_dst_bstep),
        .cfg_src_tstep(cfg_src_tstep), .cfg_dst_tstep(cfg_dst_tstep),
        .rd_addr(rd_addr), .rd_en(rd_en), .wr_addr(wr_addr), .wr_en(wr_en),
        .busy(busy), .done_irq(done_irq)
    );

    // strobe logger, sampled between edges
    always begin
        @(posedge clk);
        #5;
        if (rd_en && wr_en && ln < 64) begin
            lsrc[ln] = rd_addr;
            ldst[ln] = wr_addr;
            ln = ln + 1;
        end else if (rd_en != wr_en) begin
            ln = 99;
        end
        if (done_irq) irqn = irqn + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_run;   ctl_run = 1;   @(negedge clk); ctl_run = 0;   endtask
    task automatic pulse_halt;  ctl_halt = 1;  @(negedge clk); ctl_halt = 0;  endtask
    task automatic pulse_srst;  ctl_srst = 1;  @(negedge clk); ctl_srst = 0;  endtask
    task automatic pulse_trig;  per_trig = 1;  @(negedge clk); per_trig = 0;  endtask
    task automatic pulse_force; ctl_force = 1; @(negedge clk); ctl_force = 0; endtask
    task automatic pulse_clr;   ctl_clr = 1;   @(negedge clk); ctl_clr = 0;   endtask

    task automatic wait_idle;
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        cyc(2);
    endtask

    task automatic clear_log; ln = 0; irqn = 0; endtask

    task automatic setup(input logic wide, input int bf, input int xf,
                         input int sb, input int db, input int sbs, input int dbs,
                         input int sts, input int dts);
        cfg_wide = wide; cfg_burst = BW'(bf); cfg_xfer = TW'(xf);
        cfg_src_base = AW'(sb); cfg_dst_base = AW'(db);
        cfg_src_bstep = SW'(sbs); cfg_dst_bstep = SW'(dbs);
        cfg_src_tstep = SW'(sts); cfg_dst_tstep = SW'(dts);
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 strobes", {rd_en, wr_en, done_irq}, 0);
        check("R1 addr", {rd_addr, wr_addr}, 0);
    endtask

    task automatic t_narrow;
        setup(0, 7, 1, 'h100, 'h400, 1, 1, -7, 1);
        clear_log();
        pulse_run();
        check("R8 busy after run", busy, 1);
        check("R8 src base loaded", rd_addr, 'h100);
        check("R8 dst base loaded", wr_addr, 'h400);
        pulse_trig();
        check("R6 no strobe one edge after trigger", rd_en, 0);
        @(negedge clk);
        check("R6 strobe two edges after trigger", rd_en, 1);
        cyc(10);
        pulse_trig();
        wait_idle();
        check("R2 word count two bursts", ln, 16);
        for (int i = 0; i < 16; i++) begin
            check("R2 src addr", lsrc[i], 'h100 + (i % 8));
            check("R2 dst addr", ldst[i], 'h400 + i);
        end
        check("R5 one irq", irqn, 1);
        check("R4 narrow src re-read end", rd_addr, 'h100);
        check("R4 narrow dst continue end", wr_addr, 'h410);
    endtask

    task automatic t_wide;
        setup(1, 8, 2, 'h200, 'h800, 2, 2, -8, 0);
        clear_log();
        pulse_run();
        for (int b = 0; b < 3; b++) begin
            pulse_trig();
            cyc(8);
        end
        wait_idle();
        check("R3 wide word count", ln, 12);
        for (int i = 0; i < 12; i++) begin
            check("R3 wide src addr", lsrc[i], 'h200 + 2 * (i % 4));
            check("R3 wide dst addr", ldst[i], 'h800 + 2 * i);
        end
        check("R4 wide src re-read end", rd_addr, 'h200);
        check("R4 wide dst end one past", wr_addr, 'h818);
        check("R5 irq wide", irqn, 1);
        setup(1, 1, 0, 'h300, 'h900, 2, 2, 0, 0);
        clear_log();
        pulse_run();
        pulse_trig();
        wait_idle();
        check("R3 wide field 1 moves one word", ln, 1);
        check("R3 wide single final step", rd_addr, 'h302);
    endtask

    task automatic t_ignored;
        clear_log();
        pulse_trig();
        cyc(4);
        check("R7 trigger while stopped", {busy, rd_en}, 0);
        setup(0, 3, 0, 'h20, 'h60, 1, 1, 1, 1);
        per_trig = 1; ctl_run = 1;
        @(negedge clk);
        per_trig = 0; ctl_run = 0;
        cyc(5);
        check("R7 trigger with run dropped", ln, 0);
        check("R7 still waiting", busy, 1);
        pulse_srst();
    endtask

    task automatic t_queue;
        setup(0, 7, 1, 'h40, 'h80, 1, 1, 1, 1);
        clear_log();
        pulse_run();
        pulse_trig();
        cyc(2);
        pulse_trig();
        cyc(20);
        check("R6 held trigger runs second burst", ln, 16);
        check("R6 done after held burst", {busy, irqn[0]}, 2'b01);
    endtask

    task automatic t_clear_force;
        setup(0, 3, 2, 'h10, 'h50, 1, 1, 1, 1);
        clear_log();
        pulse_run();
        pulse_trig();
        cyc(1);
        pulse_trig();
        pulse_clr();
        cyc(6);
        check("R11 cleared trigger no burst", ln, 4);
        check("R11 still running", busy, 1);
        per_trig = 1; ctl_clr = 1;
        @(negedge clk);
        per_trig = 0; ctl_clr = 0;
        cyc(6);
        check("R11 clear wins over trigger", ln, 4);
        pulse_force();
        cyc(7);
        check("R11 force starts burst", ln, 8);
        check("R11 force burst addr", lsrc[4], 'h14);
        pulse_trig();
        cyc(1);
        pulse_srst();
        check("R10 soft reset stops", {busy, rd_en}, 0);
        check("R10 soft reset ptrs", {rd_addr, wr_addr}, 0);
        pulse_run();
        check("R10 fresh run reloads", rd_addr, 'h10);
        pulse_srst();
    endtask

    task automatic t_halt;
        setup(0, 3, 3, 'h10, 'h50, 1, 1, 1, 1);
        clear_log();
        pulse_run();
        pulse_trig();
        @(negedge clk);
        pulse_halt();
        wait_idle();
        check("R9 halt finishes burst", ln, 4);
        check("R9 halted", busy, 0);
        pulse_run();
        check("R9 resume busy", busy, 1);
        check("R9 resume keeps ptr", rd_addr, 'h14);
        pulse_trig();
        cyc(7);
        pulse_halt();
        check("R9 halt while waiting", busy, 0);
        pulse_trig();
        cyc(3);
        check("R9 trigger ignored while halted", ln, 8);
        pulse_run();
        pulse_trig();
        cyc(7);
        pulse_trig();
        wait_idle();
        check("R9 total words", ln, 16);
        for (int i = 0; i < 16; i++) begin
            check("R9 src continuity", lsrc[i], 'h10 + i);
            check("R9 dst continuity", ldst[i], 'h50 + i);
        end
        check("R5 irq after resume", irqn, 1);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_narrow();
        t_wide();
        t_ignored();
        t_queue();
        t_clear_force();
        t_halt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule